// File: doc/BRIEF.md
# Multi-Channel Register-Programmed PWM Generator

This block produces up to four independent pulse-width-modulated outputs from one input clock. Each channel is controlled by a single 32-bit word, written and read over a simple memory-mapped bus. The word holds:

- an enable bit;
- a force-high bit;
- an 8-bit duty count;
- a 13-bit prescale value.

Each channel divides the input clock by its prescale value plus one. It then walks a 256-step counter, and the output is high for the first N steps of every 256.

Changes take effect immediately. Turning a channel off, or rewriting its word, acts on the next clock edge. The period in progress is abandoned, not finished.

Software places channel n's word at byte offset n×16. Every other offset reads as zero and ignores writes.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous reset, every channel word reads as zero and every output is low.
- R2: A write stores bit 31 (enable), bit 24 (force high), bits [23:16] (duty N) and bits [12:0] (prescale S). All other bits read back as zero. A read returns the stored word in the same cycle.
- R3: Channel n's word sits at byte offset n×16, for n below the channel count. A read of any other offset returns zero. A write to any other offset changes no channel.
- R4: While enabled, a channel's step counter advances once every S+1 clocks and wraps after 256 steps. One period therefore lasts 256×(S+1) clocks.
- R5: With enable set and force high clear, the output is high during steps 0 to N-1 of each period and low otherwise. With N = 0, the output stays low.
- R6: With enable and force high both set, the output is high on every clock, whatever the duty value.
- R7: When enable is clear, the output is low from the edge that stored the word onward.
- R8: A write to a channel restarts it. After the write edge, its prescale and step counts are both zero, so the new settings act at once.
- R9: A write to one channel leaves the stored word, phase and output of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock shared by all channels |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel, active high |

## Verification
The properties assume the following about the bus:
- bus_we lasts one clock per write;
- bus_addr and bus_wdata are stable around each rising edge;
- reset is held for at least one edge before traffic starts.

The bench respects these assumptions by changing every input only on the falling edge and by issuing writes as single-cycle pulses. It keeps prescale values small so that complete periods fit in a short run. It still writes all-ones words to exercise the masking.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int WORD_W   = 32;
  localparam int DUTY_W   = 8;
  localparam int SCALE_W  = 13;
  localparam int EN_POS   = 31;
  localparam int FULL_POS = 24;
  localparam int DUTY_LSB = 16;
  localparam int STEPS    = 1 << DUTY_W;

  typedef struct packed {
    logic               en;
    logic               full;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } chan_cfg_t;

  // Split a bus word into its channel fields; unused bits are dropped.
  function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    chan_cfg_t c;
    c.en    = w[EN_POS];
    c.full  = w[FULL_POS];
    c.duty  = w[DUTY_LSB +: DUTY_W];
    c.scale = w[SCALE_W-1:0];
    return c;
  endfunction

  // Rebuild a bus word with every unused bit at zero.
  function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w                       = '0;
    w[EN_POS]               = c.en;
    w[FULL_POS]             = c.full;
    w[DUTY_LSB +: DUTY_W]   = c.duty;
    w[SCALE_W-1:0]          = c.scale;
    return w;
  endfunction

  // Output level for a given step of the 256-step cycle.
  function automatic logic level_at(input chan_cfg_t c, input logic [DUTY_W-1:0] step);
    return c.en && (c.full || (step < c.duty));
  endfunction

endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 8,
  parameter int STRIDE_LG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic                     addr_hit,
  output logic [NUM_CH-1:0]        ch_wr,
  output chan_cfg_t [NUM_CH-1:0]   cfg
);

  localparam int IDX_W = ADDR_W - STRIDE_LG2;

  logic [IDX_W-1:0] sel_idx;
  logic             low_zero;

  assign sel_idx  = bus_addr[ADDR_W-1:STRIDE_LG2];
  assign low_zero = (bus_addr[STRIDE_LG2-1:0] == '0);
  assign addr_hit = low_zero && (int'(sel_idx) < NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    assign ch_wr[i] = bus_we && addr_hit && (sel_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)           cfg[i] <= '0;
      else if (ch_wr[i]) cfg[i] <= word_to_cfg(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_hit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (sel_idx == IDX_W'(i)) bus_rdata = cfg_to_word(cfg[i]);
      end
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  chan_cfg_t         cfg,
  input  logic              restart,
  output logic              pwm,
  output logic              wrap,
  output logic [DUTY_W-1:0] step
);

  logic [SCALE_W-1:0] pre;

  assign wrap = (pre == cfg.scale);

  always_ff @(posedge clk) begin
    if (rst || restart || !cfg.en) begin
      pre  <= '0;
      step <= '0;
    end else if (wrap) begin
      pre  <= '0;
      step <= step + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  assign pwm = level_at(cfg, step);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 8,
  parameter int STRIDE_LG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  chan_cfg_t [NUM_CH-1:0]      cfg;
  logic [NUM_CH-1:0]           ch_wr;
  logic [NUM_CH-1:0]           ch_en;
  logic [NUM_CH-1:0]           ch_full;
  logic [NUM_CH-1:0]           ch_wrap;
  logic [NUM_CH*DUTY_W-1:0]    ch_step;
  logic                        addr_hit;

  pwm_regbank #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .STRIDE_LG2(STRIDE_LG2)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .addr_hit (addr_hit),
    .ch_wr    (ch_wr),
    .cfg      (cfg)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_en[i]   = cfg[i].en;
    assign ch_full[i] = cfg[i].full;

    pwm_channel u_ch (
      .clk    (clk),
      .rst    (rst),
      .cfg    (cfg[i]),
      .restart(ch_wr[i]),
      .pwm    (pwm_out[i]),
      .wrap   (ch_wrap[i]),
      .step   (ch_step[i*DUTY_W +: DUTY_W])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                addr_hit,
  input logic [31:0]         bus_rdata,
  input logic [NUM_CH-1:0]   pwm_out,
  input logic [NUM_CH-1:0]   ch_en,
  input logic [NUM_CH-1:0]   ch_full,
  input logic [NUM_CH-1:0]   ch_wr,
  input logic [NUM_CH-1:0]   ch_wrap,
  input logic [NUM_CH*8-1:0] ch_step
);

  // R1
  reset_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0));

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |-> (bus_rdata == 32'd0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |-> !pwm_out[i]);

    // R6
    full_high_chk: assert property (@(posedge clk) disable iff (rst)
      (ch_en[i] && ch_full[i]) |-> pwm_out[i]);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
      ch_wr[i] |=> (ch_step[i*8 +: 8] == 8'd0));

    // R4
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
      (ch_en[i] && !ch_wr[i] && ch_wrap[i]) |=>
        (ch_step[i*8 +: 8] == $past(ch_step[i*8 +: 8]) + 8'd1));

    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ch_en[i] && !ch_wr[i] && !ch_wrap[i]) |=> $stable(ch_step[i*8 +: 8]));
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr_hit (addr_hit),
  .bus_rdata(bus_rdata),
  .pwm_out  (pwm_out),
  .ch_en    (ch_en),
  .ch_full  (ch_full),
  .ch_wr    (ch_wr),
  .ch_wrap  (ch_wrap),
  .ch_step  (ch_step)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam logic [31:0] KEEP_MASK = 32'h81FF_1FFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] m_cfg [NCH];
  int          m_t   [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank u_dut (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_level(input int c);
    int s, step;
    s    = int'(m_cfg[c][12:0]) + 1;
    step = (m_t[c] / s) % 256;
    return m_cfg[c][31] && (m_cfg[c][24] || step < int'(m_cfg[c][23:16]));
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[3:0] == 4'd0 && int'(a[7:4]) < NCH) return m_cfg[a[7:4]];
    return 32'h0;
  endfunction

  // Reference model: time since each channel's last restart
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        m_cfg[c] = 32'h0;
        m_t[c]   = 0;
      end else if (bus_we && bus_addr[3:0] == 4'd0 && int'(bus_addr[7:4]) == c) begin
        m_cfg[c] = bus_wdata & KEEP_MASK;
        m_t[c]   = 0;
      end else if (m_cfg[c][31]) begin
        m_t[c]   = m_t[c] + 1;
      end else begin
        m_t[c]   = 0;
      end
    end
  end

  // Per-cycle comparison, a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst && !done) begin
      for (int c = 0; c < NCH; c++) begin
        bit e;
        e = exp_level(c);
        if (!m_cfg[c][31])     check(pwm_out[c] == e, "R7 off", int'(pwm_out[c]), int'(e));
        else if (m_cfg[c][24]) check(pwm_out[c] == e, "R6 full", int'(pwm_out[c]), int'(e));
        else                   check(pwm_out[c] == e, "R5 duty", int'(pwm_out[c]), int'(e));
      end
      check(bus_rdata == exp_read(bus_addr), "R2 read", int'(bus_rdata), int'(exp_read(bus_addr)));
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata == exp, tag, int'(bus_rdata), int'(exp));
  endtask

  // Count high cycles of channel c over n clocks, starting right after a write
  task automatic count_high(input int c, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out[c]) cnt++;
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: every word zero, every output low
    for (int c = 0; c < NCH; c++) read_check(8'(c * 16), 32'h0, "R1 reset word");
    check(pwm_out == '0, "R1 reset outputs", int'(pwm_out), 0);

    // R5 / R4: duty 64, prescale 0 -> 64 highs in 256 clocks
    bus_write(8'h00, 32'h8040_0000);
    count_high(0, 256, cnt);
    check(cnt == 64, "R5 duty 64 count", cnt, 64);

    // R2: all-ones write is masked on read-back; R6 force-high
    bus_write(8'h10, 32'hFFFF_FFFF);
    read_check(8'h10, 32'h81FF_1FFF, "R2 masked read");
    check(pwm_out[1] == 1'b1, "R6 force high", int'(pwm_out[1]), 1);

    // R5: duty 0 stays low over a full period
    bus_write(8'h20, 32'h8000_0003);
    count_high(2, 1024, cnt);
    check(cnt == 0, "R5 duty zero", cnt, 0);

    // R4: prescale 2, duty 1 -> 3 highs in 768 clocks, next period repeats
    bus_write(8'h30, 32'h8001_0002);
    count_high(3, 768, cnt);
    check(cnt == 3, "R4 period 768 count", cnt, 3);
    check(pwm_out[3] == 1'b1, "R4 next period starts high", int'(pwm_out[3]), 1);

    // R3: unmapped offsets read zero, writes ignored
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h40, 32'hFFFF_FFFF);
    read_check(8'h04, 32'h0, "R3 misaligned read");
    read_check(8'h40, 32'h0, "R3 beyond channels read");
    read_check(8'h00, 32'h8040_0000, "R3 ch0 untouched");

    // R8: rewriting ch0 restarts at step 0; duty 1 high one clock then low
    repeat (37) @(negedge clk);
    bus_write(8'h00, 32'h8001_0000);
    check(pwm_out[0] == 1'b1, "R8 restart step0", int'(pwm_out[0]), 1);
    @(negedge clk);
    check(pwm_out[0] == 1'b0, "R8 step1 low", int'(pwm_out[0]), 0);

    // R9: ch3 word kept after ch0 write (phase compared every cycle)
    read_check(8'h30, 32'h8001_0002, "R9 ch3 word kept");

    // R7: clearing enable drops the output even with force-high set
    bus_write(8'h10, 32'h0100_00FF);
    check(pwm_out[1] == 1'b0, "R7 disable immediate", int'(pwm_out[1]), 0);

    repeat (600) @(negedge clk);
    finish_run();
  end

endmodule